// File: doc/BRIEF.md
# Four-by-Five Bus Crossbar Switch

This block links four bus masters to five bus slaves. Every master and slave port carries a 32-bit address and a 64-bit data path. A master raises a request with its address, a write flag and write data. It keeps all of them steady until it sees an acknowledge, which comes back together with the read data from the slave it reached. The top three address bits pick the target slave port. Any master can reach any slave. Masters aimed at different slaves are served in the same cycle.

Each slave port has its own arbiter, which holds a registered owner. While one master owns a port, the other masters asking for that port see a stall and wait. Ownership ends in either of two cases: the slave acknowledges the transfer, or the owner withdraws its request. The arbiter then picks a new owner in the following cycle. A per-port configuration bit selects the arbitration mode. In round-robin mode, which is the default, the search starts at the master after the last one granted. In fixed-priority mode the lowest master index always wins.

Top module: `xbar_switch`

## Requirements
- R1: The slave port is chosen by address bits [31:29]: values 0 to 4 select slave 0 to 4, and values 5, 6 and 7 all select slave 4.
- R2: A slave port drives its request high only for its owning master, and it forwards that master's address, write flag and write data unchanged.
- R3: A master's acknowledge and read data come only from the slave it owns. While it owns that slave, the master's acknowledge equals the slave's acknowledge in the same cycle.
- R4: Masters aimed at distinct slaves are all granted at the same clock edge and run at the same time.
- R5: At most one master owns a slave port in any cycle. A requesting master that holds no ownership sees stall = 1 and acknowledge = 0.
- R6: The owner of a slave port stays fixed until the slave acknowledges or the owner drops its request, however many cycles that takes.
- R7: With the port's mode bit at 0 (round-robin), a new grant goes to the first requesting master after the last granted one, in cyclic order. Four masters that keep requesting are served in the order 0, 1, 2, 3, 0, and so on.
- R8: With the port's mode bit at 1 (fixed priority), the lowest-indexed requesting master wins every arbitration.
- R9: A request to an idle port is granted at the next clock edge. After an acknowledge, the port has one cycle with no owner before the next grant, so back-to-back grants on one port come two cycles apart.
- R10: After reset no port has an owner, every slave request and master acknowledge is 0, and each port's round-robin search starts at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 4 | Request, one bit per master |
| m_we | input | 4 | Write flag, one bit per master |
| m_addr | input | 128 | Addresses, master m at bits [32m+31:32m] |
| m_wdata | input | 256 | Write data, master m at bits [64m+63:64m] |
| m_rdata | output | 256 | Read data back to each master |
| m_ack | output | 4 | Transfer complete, one bit per master |
| m_stall | output | 4 | Master is requesting but owns no port |
| s_req | output | 5 | Request, one bit per slave |
| s_we | output | 5 | Write flag, one bit per slave |
| s_addr | output | 160 | Address to each slave |
| s_wdata | output | 320 | Write data to each slave |
| s_rdata | input | 320 | Read data from each slave |
| s_ack | input | 5 | Transfer complete, one bit per slave |
| arb_fixed | input | 5 | Per slave: 0 round-robin, 1 fixed priority |

## Verification
The assertions rely on three assumptions about the inputs. First, a master keeps its address, write flag and write data steady from raising a request until its acknowledge. Second, a master changes its target only after it has dropped its request or seen the acknowledge. Third, a slave acknowledges only while its own request is high. The bench meets these assumptions in three ways. Its master stimulus changes address fields only when the request is low or right after an acknowledge. Its slave model forms the acknowledge from the slave request and a per-port enable. Its read data is a fixed function of the forwarded address.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic {
    ARB_ROUND_ROBIN = 1'b0,
    ARB_FIXED_PRIO  = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned N_SLAVES = 5,
  parameter int unsigned REGION_W = 3,
  localparam int unsigned SW = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SW-1:0]     sel
);
  logic [REGION_W-1:0] region;

  always_comb begin
    region = addr[ADDR_W-1 -: REGION_W];
    if (int'(region) < int'(N_SLAVES)) sel = SW'(region);
    else                               sel = SW'(N_SLAVES - 1);
  end

  always_comb begin
    assert_sel_in_range_R1: assert (int'(sel) < int'(N_SLAVES));
  end
endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int unsigned N_M = 4,
  localparam int unsigned IW = (N_M > 1) ? $clog2(N_M) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_M-1:0]      req_vec,
  input  logic                done,
  input  xbar_pkg::arb_mode_e mode,
  output logic                owner_vld,
  output logic [IW-1:0]       owner
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] pick;
  logic          found;
  logic          release_own;
  int unsigned   idx;

  // Search order: from last grant + 1 (round-robin) or from index 0 (fixed)
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 0; k < int'(N_M); k++) begin
      if (mode == xbar_pkg::ARB_FIXED_PRIO) idx = k;
      else idx = (int'(last_q) + 1 + k) % N_M;
      if (!found && req_vec[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  assign release_own = owner_vld && (!req_vec[owner] || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_vld <= 1'b0;
      owner     <= '0;
      last_q    <= IW'(N_M - 1);
    end else if (release_own) begin
      owner_vld <= 1'b0;
    end else if (!owner_vld && found) begin
      owner_vld <= 1'b1;
      owner     <= pick;
      last_q    <= pick;
    end
  end

  assert_hold_owner_R6: assert property (@(posedge clk) disable iff (rst)
    (owner_vld && req_vec[owner] && !done) |=> (owner_vld && owner == $past(owner)));

  assert_release_on_done_R6: assert property (@(posedge clk) disable iff (rst)
    (owner_vld && done) |=> !owner_vld);

  assert_grant_to_requester_R5: assert property (@(posedge clk) disable iff (rst)
    (owner_vld && !$past(owner_vld)) |-> (($past(req_vec) & (N_M'(1) << owner)) != '0));

  assert_rr_moves_on_R7: assert property (@(posedge clk) disable iff (rst)
    (!owner_vld && mode == xbar_pkg::ARB_ROUND_ROBIN &&
     ((req_vec & ~(N_M'(1) << last_q)) != '0)) |=> (owner != $past(last_q)));

  assert_fixed_lowest_R8: assert property (@(posedge clk) disable iff (rst)
    (!owner_vld && mode == xbar_pkg::ARB_FIXED_PRIO && req_vec[0]) |=> (owner_vld && owner == '0));
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int unsigned N_M      = 4,
  parameter int unsigned N_S      = 5,
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 64,
  parameter int unsigned REGION_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_M-1:0]     m_req,
  input  logic [N_M-1:0]     m_we,
  input  logic [N_M*AW-1:0]  m_addr,
  input  logic [N_M*DW-1:0]  m_wdata,
  output logic [N_M*DW-1:0]  m_rdata,
  output logic [N_M-1:0]     m_ack,
  output logic [N_M-1:0]     m_stall,
  output logic [N_S-1:0]     s_req,
  output logic [N_S-1:0]     s_we,
  output logic [N_S*AW-1:0]  s_addr,
  output logic [N_S*DW-1:0]  s_wdata,
  input  logic [N_S*DW-1:0]  s_rdata,
  input  logic [N_S-1:0]     s_ack,
  input  logic [N_S-1:0]     arb_fixed
);
  localparam int unsigned MIW = (N_M > 1) ? $clog2(N_M) : 1;
  localparam int unsigned SW  = (N_S > 1) ? $clog2(N_S) : 1;

  logic [SW-1:0]  tgt      [N_M];
  logic [AW-1:0]  maddr_a  [N_M];
  logic [DW-1:0]  mwdata_a [N_M];
  logic [DW-1:0]  srdata_a [N_S];
  logic [MIW-1:0] own_idx  [N_S];
  logic [N_S-1:0] own_vld;
  logic [N_M-1:0] gnt;

  for (genvar m = 0; m < N_M; m++) begin : g_mst_in
    assign maddr_a[m]  = m_addr[m*AW +: AW];
    assign mwdata_a[m] = m_wdata[m*DW +: DW];
    xbar_decode #(.ADDR_W(AW), .N_SLAVES(N_S), .REGION_W(REGION_W)) u_dec (
      .addr (maddr_a[m]),
      .sel  (tgt[m])
    );
  end

  for (genvar s = 0; s < N_S; s++) begin : g_slv
    logic [N_M-1:0] rv;
    for (genvar m = 0; m < N_M; m++) begin : g_rv
      assign rv[m] = m_req[m] && (tgt[m] == SW'(s));
    end

    xbar_arbiter #(.N_M(N_M)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .req_vec   (rv),
      .done      (s_ack[s] && s_req[s]),
      .mode      (xbar_pkg::arb_mode_e'(arb_fixed[s])),
      .owner_vld (own_vld[s]),
      .owner     (own_idx[s])
    );

    assign srdata_a[s]           = s_rdata[s*DW +: DW];
    assign s_req[s]              = own_vld[s] && rv[own_idx[s]];
    assign s_we[s]               = m_we[own_idx[s]];
    assign s_addr[s*AW +: AW]    = maddr_a[own_idx[s]];
    assign s_wdata[s*DW +: DW]   = mwdata_a[own_idx[s]];
  end

  for (genvar m = 0; m < N_M; m++) begin : g_mst_out
    logic [N_S-1:0] gm;
    for (genvar s = 0; s < N_S; s++) begin : g_gm
      assign gm[s] = own_vld[s] && (own_idx[s] == MIW'(m));
    end
    assign gnt[m]              = m_req[m] && gm[tgt[m]];
    assign m_ack[m]            = gnt[m] && s_ack[tgt[m]];
    assign m_rdata[m*DW +: DW] = srdata_a[tgt[m]];
    assign m_stall[m]          = m_req[m] && !gnt[m];

    assert_one_port_per_master_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gm));
    assert_ack_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
      m_ack[m] |-> m_req[m]);
    assert_stall_excludes_ack_R5: assert property (@(posedge clk) disable iff (rst)
      !(m_stall[m] && m_ack[m]));
  end

  assert_idle_after_reset_R10: assert property (@(posedge clk)
    $fell(rst) |-> (s_req == '0 && m_ack == '0));
endmodule

// File: tb/tb_xbar_switch.sv
module tb_xbar_switch;
  localparam int NM = 4;
  localparam int NS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [NM-1:0]    m_req, m_we, m_ack, m_stall;
  logic [NM*32-1:0] m_addr;
  logic [NM*64-1:0] m_wdata, m_rdata;
  logic [NS-1:0]    s_req, s_we, s_ack, arb_fixed, ack_en;
  logic [NS*32-1:0] s_addr;
  logic [NS*64-1:0] s_wdata, s_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  xbar_switch dut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack), .m_stall(m_stall),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ack(s_ack), .arb_fixed(arb_fixed)
  );

  // Slave model: ack while enabled, read data is a function of the address
  assign s_ack = s_req & ack_en;
  for (genvar s = 0; s < NS; s++) begin : g_slave_model
    assign s_rdata[s*64 +: 64] = {s_addr[s*32 +: 32] ^ 32'h5A00_0000, 32'(s)};
  end

  function automatic logic [63:0] exp_rd(int s, logic [31:0] a);
    return {a ^ 32'h5A00_0000, 32'(s)};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_req(int m, logic [31:0] a, logic we);
    m_addr[m*32 +: 32]  = a;
    m_wdata[m*64 +: 64] = {~a, a};
    m_we[m]             = we;
    m_req[m]            = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1; m_req = '0; m_we = '0; m_addr = '0; m_wdata = '0;
    arb_fixed = '0; ack_en = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int ack_idx();
    for (int m = 0; m < NM; m++) if (m_ack[m]) return m;
    return -1;
  endfunction

  task automatic t_reset();
    do_reset();
    #1;
    check(s_req == '0, "R10 slave req after reset", 64'(s_req), 0);
    check(m_ack == '0, "R10 master ack after reset", 64'(m_ack), 0);
    set_req(0, 32'h0000_0100, 1'b0);
    #1;
    check(m_stall[0] == 1'b1, "R10 stall before grant", 64'(m_stall), 1);
    check(s_req == '0, "R9 no grant in request cycle", 64'(s_req), 0);
    @(negedge clk); #1;
    check(s_req == 5'b00001, "R9 grant at next edge", 64'(s_req), 1);
    m_req[0] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_decode();
    do_reset();
    for (int r = 0; r < 8; r++) begin
      logic [31:0] a;
      int es;
      a  = {r[2:0], 29'h0ABC_D00 + 29'(r)};
      es = (r < NS) ? r : NS - 1;
      set_req(0, a, r[0]);
      @(negedge clk); #1;
      check(s_req == NS'(1 << es), "R1 decode region", 64'(s_req), 64'(1 << es));
      check(s_addr[es*32 +: 32] == a, "R2 address forwarded", 64'(s_addr[es*32 +: 32]), 64'(a));
      check(s_wdata[es*64 +: 64] == {~a, a}, "R2 write data forwarded", s_wdata[es*64 +: 64], {~a, a});
      check(s_we[es] == r[0], "R2 write flag forwarded", 64'(s_we[es]), 64'(r[0]));
      check(m_ack[0] == 1'b1, "R3 ack returned", 64'(m_ack), 1);
      check(m_rdata[63:0] == exp_rd(es, a), "R3 read data returned", m_rdata[63:0], exp_rd(es, a));
      m_req[0] = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_concurrent();
    do_reset();
    ack_en = '0;
    for (int m = 0; m < NM; m++) set_req(m, {3'(3 - m), 29'h0000_0040 * 29'(m + 1)}, 1'b1);
    @(negedge clk); #1;
    check(s_req == 5'b01111, "R4 all granted together", 64'(s_req), 64'h0f);
    check(m_stall == '0, "R4 no stall on distinct slaves", 64'(m_stall), 0);
    for (int m = 0; m < NM; m++)
      check(s_addr[(3 - m)*32 +: 32] == m_addr[m*32 +: 32], "R4 routing",
            64'(s_addr[(3 - m)*32 +: 32]), 64'(m_addr[m*32 +: 32]));
    ack_en = '1; #1;
    check(m_ack == 4'hf, "R4 concurrent acks", 64'(m_ack), 64'hf);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_hold();
    do_reset();
    ack_en = '0;
    set_req(1, 32'h2000_0010, 1'b0);
    set_req(3, 32'h2000_0030, 1'b0);
    @(negedge clk); #1;
    check(s_req[1] && s_addr[63:32] == 32'h2000_0010, "R5 one owner", 64'(s_addr[63:32]), 64'h2000_0010);
    check(m_stall == 4'b1000, "R5 loser stalls", 64'(m_stall), 64'h8);
    check(m_ack == '0, "R5 no ack while waiting", 64'(m_ack), 0);
    repeat (5) @(negedge clk);
    #1;
    check(s_addr[63:32] == 32'h2000_0010, "R6 owner held", 64'(s_addr[63:32]), 64'h2000_0010);
    ack_en[1] = 1'b1; #1;
    check(m_ack == 4'b0010, "R3 ack to owner only", 64'(m_ack), 64'h2);
    @(negedge clk); #1;
    check(s_req[1] == 1'b0, "R9 idle cycle after ack", 64'(s_req), 0);
    m_req[1] = 1'b0;
    @(negedge clk); #1;
    check(m_ack == 4'b1000 && s_addr[63:32] == 32'h2000_0030, "R5 waiting master served",
          64'(m_ack), 64'h8);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_rotate(logic [NM-1:0] who, int exp_seq[8], string tag);
    int got = 0;
    int last_cyc = -1;
    do_reset();
    for (int m = 0; m < NM; m++) if (who[m]) set_req(m, 32'h4000_0000 + 32'(m * 8), 1'b0);
    for (int c = 0; c < 24 && got < 8; c++) begin
      int a;
      @(negedge clk); #1;
      check($countones(m_ack) <= 1, "R5 single ack per slave", 64'(m_ack), 0);
      a = ack_idx();
      if (a >= 0) begin
        check(a == exp_seq[got], tag, 64'(a), 64'(exp_seq[got]));
        if (last_cyc >= 0) check(c - last_cyc == 2, "R9 grant spacing", 64'(c - last_cyc), 2);
        last_cyc = c;
        got++;
      end
    end
    check(got == 8, tag, 64'(got), 8);
    m_req = '0;
    @(negedge clk);
  endtask

  task automatic t_fixed();
    int got = 0;
    do_reset();
    arb_fixed[2] = 1'b1;
    set_req(0, 32'h4000_0000, 1'b0);
    set_req(2, 32'h4000_0010, 1'b0);
    set_req(3, 32'h4000_0018, 1'b0);
    for (int c = 0; c < 40 && got < 7; c++) begin
      int a;
      @(negedge clk); #1;
      a = ack_idx();
      if (a >= 0) begin
        check(a == ((got < 4) ? 0 : 2), "R8 lowest index wins", 64'(a), 64'((got < 4) ? 0 : 2));
        got++;
        if (got == 4) begin
          @(negedge clk);
          m_req[0] = 1'b0;
        end
      end
    end
    check(got == 7, "R8 grant count", 64'(got), 7);
    m_req = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int all4[8] = '{0, 1, 2, 3, 0, 1, 2, 3};
    int odd2[8] = '{1, 3, 1, 3, 1, 3, 1, 3};
    t_reset();
    t_decode();
    t_concurrent();
    t_hold();
    t_rotate(4'b1111, all4, "R7 round-robin order four masters");
    t_rotate(4'b1010, odd2, "R7 round-robin order two masters");
    t_fixed();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule